// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a small group of memory blocks shared by several processor caches. For every block it keeps one presence bit per processor and one dirty bit, together with the home copy of the block's data. Processors send read and write requests over a valid/ready request channel. The controller looks up the block's directory entry and sends point-to-point messages only to the caches that the entry records as holding a copy. It then collects their acknowledgements, and any recalled data, on an acknowledge channel. It updates the home copy and the directory entry and answers the requester on a response channel.

There are three message kinds. An invalidate removes a clean copy. A recall-and-share fetches a dirty copy and leaves the owner holding a clean shared copy. A recall-and-invalidate fetches a dirty copy and removes it. A write grant makes the requester the single dirty owner. A read of a dirty block hands the owner's data to the requester and writes it back to the home copy. The controller handles one transaction at a time. Any new request waits, with ready held low, until the current response has been taken.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, every presence bit and every dirty bit is clear and the home copy of block b holds MEM_SEED + b. The controller is idle, with `req_ready` high and `msg_valid` and `rsp_valid` low.
- R2: A read of a block whose dirty bit is clear sends no message. It returns the home copy and adds the requester's presence bit, and existing sharers keep their bits.
- R3: A read by processor i of a block that another processor owns sends exactly one recall-and-share message (`msg_kind` = 1) to the owner. The reply carries the data from the owner's acknowledge. That data becomes the home copy, the dirty bit clears, and both the owner and i stay recorded as sharers.
- R4: A write by processor i to a clean block sends an invalidate (`msg_kind` = 0) to every recorded sharer other than i, one message each, in ascending processor index. No other processor receives a message.
- R5: A write grant is sent only after every targeted cache has acknowledged. The reply carries the home copy. Afterwards only i's presence bit is set and the dirty bit is set.
- R6: A write by processor i to a block that another processor owns sends one recall-and-invalidate message (`msg_kind` = 2) to the owner. The recalled data becomes the home copy and is returned to i, and afterwards i is the only recorded holder and the block is dirty.
- R7: Whenever a block's dirty bit is set, exactly one presence bit of that block is set.
- R8: A read or write from the processor that already owns the block sends no message. It leaves the directory entry unchanged and replies with the home copy.
- R9: From the cycle a request is accepted until its response is taken, `req_ready` stays low and further requests to any block wait.
- R10: `ack_ready` is high only for a source that has an outstanding message in the current transaction. An acknowledge from any other source is refused and does not affect the transaction.
- R11: While `msg_valid` or `rsp_valid` is high and the matching ready is low, that channel's outputs hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_src | input | PIW | Requesting processor index |
| req_write | input | 1 | 1 = write (ownership) request, 0 = read |
| req_addr | input | AW | Block index |
| msg_valid | output | 1 | Coherence message present |
| msg_ready | input | 1 | Target network accepts the message |
| msg_dst | output | PIW | Destination cache index |
| msg_kind | output | 2 | 0 invalidate, 1 recall-and-share, 2 recall-and-invalidate |
| ack_valid | input | 1 | Acknowledge present |
| ack_ready | output | 1 | Acknowledge accepted |
| ack_src | input | PIW | Acknowledging cache index |
| ack_data | input | DW | Recalled block data (ignored for invalidate acks) |
| rsp_valid | output | 1 | Response to the requester present |
| rsp_ready | input | 1 | Requester accepts the response |
| rsp_dst | output | PIW | Requester index |
| rsp_data | output | DW | Block data returned to the requester |

## Verification
The situation hardest to reach from the ports is a transaction that is still collecting acknowledges while stray acknowledges and a second, stalled request press on it. In that window the controller must neither finish early nor accept extra input. The bench keeps its own directory and data model and delays every genuine acknowledge by a few cycles. During those cycles it offers an acknowledge from the requester, which is never a target. A second request is driven while a multi-sharer invalidation is still open. Back-pressure on the message and response channels follows a fixed pattern so that hold cycles occur inside every transaction.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        MSG_INV        = 2'd0,
        MSG_RECALL_SHR = 2'd1,
        MSG_RECALL_INV = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_REPLY = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/coh_dir_pick.sv
module coh_dir_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic          found,
    output logic [IW-1:0] idx
);

    // lowest set bit wins: scan from the top so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
    parameter int          NPROC    = 4,
    parameter int          NBLK     = 16,
    parameter int          DW       = 32,
    parameter logic [31:0] MEM_SEED = 32'h5EED_0000,
    localparam int         AW       = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [AW-1:0]               upd_idx,
    input  logic [NPROC-1:0]            upd_pres,
    input  logic                        upd_dirty,
    input  logic                        mem_we,
    input  logic [DW-1:0]               mem_wdata,
    input  logic [AW-1:0]               rd_idx,
    output logic [DW-1:0]               rd_data,
    output logic [NBLK-1:0][NPROC-1:0]  pres_o,
    output logic [NBLK-1:0]             dirty_o
);

    logic [NBLK-1:0][DW-1:0] mem_all;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        logic [NPROC-1:0] pres_d,  pres_q;
        logic             dirty_d, dirty_q;
        logic [DW-1:0]    data_d,  data_q;
        logic             hit;

        assign hit = upd_en && (upd_idx == AW'(b));

        always_comb begin
            pres_d  = pres_q;
            dirty_d = dirty_q;
            data_d  = data_q;
            if (hit) begin
                pres_d  = upd_pres;
                dirty_d = upd_dirty;
                if (mem_we) begin
                    data_d = mem_wdata;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pres_q  <= '0;
                dirty_q <= 1'b0;
                data_q  <= DW'(MEM_SEED) + DW'(b);
            end else begin
                pres_q  <= pres_d;
                dirty_q <= dirty_d;
                data_q  <= data_d;
            end
        end

        assign pres_o[b]  = pres_q;
        assign dirty_o[b] = dirty_q;
        assign mem_all[b] = data_q;
    end

    assign rd_data = mem_all[rd_idx];

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter int          NPROC    = 4,
    parameter int          NBLK     = 16,
    parameter int          DW       = 32,
    parameter logic [31:0] MEM_SEED = 32'h5EED_0000,
    localparam int         PIW      = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int         AW       = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [PIW-1:0] req_src,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    output logic           msg_valid,
    input  logic           msg_ready,
    output logic [PIW-1:0] msg_dst,
    output logic [1:0]     msg_kind,
    input  logic           ack_valid,
    output logic           ack_ready,
    input  logic [PIW-1:0] ack_src,
    input  logic [DW-1:0]  ack_data,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic [PIW-1:0] rsp_dst,
    output logic [DW-1:0]  rsp_data
);

    typedef struct packed {
        ctl_state_e       st;
        logic [PIW-1:0]   src;
        logic             wr;
        logic [AW-1:0]    addr;
        msg_kind_e        kind;
        logic [NPROC-1:0] tosend;
        logic [NPROC-1:0] pend;
        logic [NPROC-1:0] new_pres;
        logic             new_dirty;
        logic             mem_upd;
        logic [DW-1:0]    data;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NBLK-1:0][NPROC-1:0] pres_all;
    logic [NBLK-1:0]            dirty_all;
    logic [DW-1:0]              home_data;
    logic                       upd_en;
    logic                       mem_we;
    logic                       pick_found;
    logic [PIW-1:0]             pick_idx;
    logic [NPROC-1:0]           src_bit;
    logic [NPROC-1:0]           cur_pres;
    logic                       cur_dirty;
    logic [NPROC-1:0]           targets;

    coh_dir_store #(
        .NPROC    (NPROC),
        .NBLK     (NBLK),
        .DW       (DW),
        .MEM_SEED (MEM_SEED)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (upd_en),
        .upd_idx   (ctl_q.addr),
        .upd_pres  (ctl_q.new_pres),
        .upd_dirty (ctl_q.new_dirty),
        .mem_we    (mem_we),
        .mem_wdata (ctl_q.data),
        .rd_idx    (req_addr),
        .rd_data   (home_data),
        .pres_o    (pres_all),
        .dirty_o   (dirty_all)
    );

    coh_dir_pick #(
        .N (NPROC)
    ) pick_i (
        .mask  (ctl_q.tosend),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign msg_dst  = pick_idx;
    assign msg_kind = ctl_q.kind;
    assign rsp_dst  = ctl_q.src;
    assign rsp_data = ctl_q.data;

    always_comb begin
        ctl_d     = ctl_q;
        req_ready = 1'b0;
        msg_valid = 1'b0;
        ack_ready = 1'b0;
        rsp_valid = 1'b0;
        upd_en    = 1'b0;
        mem_we    = 1'b0;
        src_bit   = NPROC'(1) << req_src;
        cur_pres  = pres_all[req_addr];
        cur_dirty = dirty_all[req_addr];
        targets   = '0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    ctl_d.st   = ST_XFER;
                    ctl_d.src  = req_src;
                    ctl_d.wr   = req_write;
                    ctl_d.addr = req_addr;
                    ctl_d.data = home_data;
                    ctl_d.kind = MSG_INV;
                    if (cur_dirty && cur_pres[req_src]) begin
                        // requester already owns the block: nothing to do
                        ctl_d.new_pres  = cur_pres;
                        ctl_d.new_dirty = 1'b1;
                        ctl_d.mem_upd   = 1'b0;
                    end else if (!req_write && !cur_dirty) begin
                        ctl_d.new_pres  = cur_pres | src_bit;
                        ctl_d.new_dirty = 1'b0;
                        ctl_d.mem_upd   = 1'b0;
                    end else if (!req_write) begin
                        targets         = cur_pres;
                        ctl_d.kind      = MSG_RECALL_SHR;
                        ctl_d.new_pres  = cur_pres | src_bit;
                        ctl_d.new_dirty = 1'b0;
                        ctl_d.mem_upd   = 1'b1;
                    end else if (!cur_dirty) begin
                        targets         = cur_pres & ~src_bit;
                        ctl_d.new_pres  = src_bit;
                        ctl_d.new_dirty = 1'b1;
                        ctl_d.mem_upd   = 1'b0;
                    end else begin
                        targets         = cur_pres;
                        ctl_d.kind      = MSG_RECALL_INV;
                        ctl_d.new_pres  = src_bit;
                        ctl_d.new_dirty = 1'b1;
                        ctl_d.mem_upd   = 1'b1;
                    end
                    ctl_d.tosend = targets;
                    ctl_d.pend   = targets;
                end
            end

            ST_XFER: begin
                if (pick_found) begin
                    msg_valid = 1'b1;
                    if (msg_ready) begin
                        ctl_d.tosend[pick_idx] = 1'b0;
                    end
                end
                ack_ready = ctl_q.pend[ack_src];
                if (ack_valid && ack_ready) begin
                    ctl_d.pend[ack_src] = 1'b0;
                    if (ctl_q.kind != MSG_INV) begin
                        ctl_d.data = ack_data;
                    end
                end
                if ((ctl_q.tosend == '0) && (ctl_q.pend == '0)) begin
                    upd_en   = 1'b1;
                    mem_we   = ctl_q.mem_upd;
                    ctl_d.st = ST_REPLY;
                end
            end

            ST_REPLY: begin
                rsp_valid = 1'b1;
                if (rsp_ready) begin
                    ctl_d.st = ST_IDLE;
                end
            end

            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
    parameter int  NPROC = 4,
    parameter int  NBLK  = 16,
    parameter int  DW    = 32,
    localparam int PIW   = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       msg_valid,
    input logic                       msg_ready,
    input logic [PIW-1:0]             msg_dst,
    input logic [1:0]                 msg_kind,
    input logic                       rsp_valid,
    input logic                       rsp_ready,
    input logic [PIW-1:0]             rsp_dst,
    input logic [DW-1:0]              rsp_data,
    input logic [NBLK-1:0][NPROC-1:0] pres_all,
    input logic [NBLK-1:0]            dirty_all,
    input logic [AW-1:0]              cur_addr,
    input logic                       cur_wr
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dirty_all == '0) && (pres_all == '0));

    for (genvar b = 0; b < NBLK; b++) begin : g_own
        // R7
        dirty_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_all[b] |-> ($countones(pres_all[b]) == 1));
    end

    // R4
    msg_to_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> pres_all[cur_addr][msg_dst]);

    // R5
    write_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cur_wr) |->
            (dirty_all[cur_addr] && (pres_all[cur_addr] == (NPROC'(1) << rsp_dst))));

    // R9
    req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_dst) && $stable(msg_kind));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_dst) && $stable(rsp_data));

endmodule

bind coh_dir_ctrl coh_dir_chk #(
    .NPROC (NPROC),
    .NBLK  (NBLK),
    .DW    (DW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_dst   (msg_dst),
    .msg_kind  (msg_kind),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_dst   (rsp_dst),
    .rsp_data  (rsp_data),
    .pres_all  (pres_all),
    .dirty_all (dirty_all),
    .cur_addr  (ctl_q.addr),
    .cur_wr    (ctl_q.wr)
);

// File: tb/coh_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_dir_ctrl_tb_top;

    localparam int          NPROC = 4;
    localparam int          NBLK  = 16;
    localparam int          DW    = 32;
    localparam int          PIW   = 2;
    localparam int          AW    = 4;
    localparam logic [31:0] SEED  = 32'h5EED_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [PIW-1:0] req_src = '0;
    logic           req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic           msg_valid;
    logic           msg_ready = 1'b0;
    logic [PIW-1:0] msg_dst;
    logic [1:0]     msg_kind;
    logic           ack_valid = 1'b0;
    logic           ack_ready;
    logic [PIW-1:0] ack_src = '0;
    logic [DW-1:0]  ack_data = '0;
    logic           rsp_valid;
    logic           rsp_ready = 1'b0;
    logic [PIW-1:0] rsp_dst;
    logic [DW-1:0]  rsp_data;

    always #2.5 clk = ~clk;

    coh_dir_ctrl #(
        .NPROC (NPROC), .NBLK (NBLK), .DW (DW), .MEM_SEED (SEED)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_src (req_src),
        .req_write (req_write), .req_addr (req_addr),
        .msg_valid (msg_valid), .msg_ready (msg_ready), .msg_dst (msg_dst),
        .msg_kind (msg_kind),
        .ack_valid (ack_valid), .ack_ready (ack_ready), .ack_src (ack_src),
        .ack_data (ack_data),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_dst (rsp_dst),
        .rsp_data (rsp_data)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // bench-side model of the directory, home memory and cache-held data
    logic [NPROC-1:0] m_pres  [NBLK];
    bit               m_dirty [NBLK];
    logic [DW-1:0]    m_mem   [NBLK];
    logic [DW-1:0]    own_data[NPROC];
    int               tok = 0;

    // scoreboard queues
    logic [3:0]  exp_msg_q[$];       // {dst, kind}
    string       exp_msg_tag[$];
    logic [33:0] exp_rsp_q[$];       // {dst, data}
    string       exp_rsp_tag[$];
    logic [3:0]  ack_q[$];           // {src, kind}
    int          ack_wait = 0;
    int          bogus_src = -1;
    bit          txn_open = 1'b0;
    string       cur_tag = "";

    task automatic issue(int src, bit wr, int addr, string tag);
        logic [NPROC-1:0] p;
        bit               d;
        logic [DW-1:0]    data;
        int               own;
        @(negedge clk);
        req_valid = 1'b1;
        req_src   = PIW'(src);
        req_write = wr;
        req_addr  = AW'(addr);
        while (!req_ready) @(negedge clk);
        // accepted at the coming edge: compute expectations
        p = m_pres[addr];
        d = m_dirty[addr];
        own = 0;
        for (int i = 0; i < NPROC; i++) if (p[i]) own = i;
        if (d && p[src]) begin
            data = m_mem[addr];
        end else if (!wr && !d) begin
            data = m_mem[addr];
            p[src] = 1'b1;
        end else if (!wr) begin
            exp_msg_q.push_back({2'(own), 2'd1}); exp_msg_tag.push_back(tag);
            data = own_data[own];
            m_mem[addr] = data;
            p[src] = 1'b1;
            d = 1'b0;
        end else if (!d) begin
            for (int i = 0; i < NPROC; i++) begin
                if (p[i] && i != src) begin
                    exp_msg_q.push_back({2'(i), 2'd0}); exp_msg_tag.push_back(tag);
                end
            end
            data = m_mem[addr];
            p = '0; p[src] = 1'b1;
            d = 1'b1;
        end else begin
            exp_msg_q.push_back({2'(own), 2'd2}); exp_msg_tag.push_back(tag);
            data = own_data[own];
            m_mem[addr] = data;
            p = '0; p[src] = 1'b1;
            d = 1'b1;
        end
        if (wr && !(m_dirty[addr] && m_pres[addr][src])) begin
            tok++;
            own_data[src] = 32'hC0DE_0000 + DW'(tok * 16 + src);
        end
        m_pres[addr]  = p;
        m_dirty[addr] = d;
        exp_rsp_q.push_back({2'(src), data}); exp_rsp_tag.push_back(tag);
        cur_tag   = tag;
        bogus_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        txn_open  = 1'b1;
    endtask

    task automatic wait_idle();
        while (txn_open || exp_rsp_q.size() != 0 || ack_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // responder / monitor, one evaluation per cycle, away from the active edge
    int          cyc = 0;
    bit          msg_hold = 1'b0;
    logic [3:0]  msg_hold_v = '0;
    bit          rsp_hold = 1'b0;
    logic [33:0] rsp_hold_v = '0;

    always begin
        bit real_ack;
        bit fake_ack;
        @(negedge clk);
        cyc++;
        real_ack = 1'b0;
        fake_ack = 1'b0;
        if (rst_n) begin
            msg_ready = (cyc % 4) != 1;
            rsp_ready = (cyc % 3) != 0;
            if (ack_q.size() != 0 && ack_wait == 0) begin
                ack_valid = 1'b1;
                ack_src   = ack_q[0][3:2];
                ack_data  = (ack_q[0][1:0] != 2'd0) ? own_data[ack_q[0][3:2]] : 32'hDEAD_0000;
                real_ack  = 1'b1;
            end else if (ack_q.size() != 0 && bogus_src >= 0) begin
                ack_valid = 1'b1;
                ack_src   = PIW'(bogus_src);
                ack_data  = 32'hBAD0_BAD0;
                fake_ack  = 1'b1;
            end else begin
                ack_valid = 1'b0;
            end
            if (ack_wait > 0) ack_wait--;
        end
        #1;
        if (rst_n) begin
            // acknowledge channel
            if (real_ack) begin
                chk(ack_ready, "R5", {cur_tag, " pending ack accepted"}, 64'(ack_ready), 64'd1);
                if (ack_ready) begin
                    void'(ack_q.pop_front());
                    ack_wait = 2;
                end
            end
            if (fake_ack) begin
                // R10: stray acknowledge refused
                chk(!ack_ready, "R10", {cur_tag, " stray ack refused"}, 64'(ack_ready), 64'd0);
            end
            // message channel
            if (msg_hold) begin
                chk(msg_valid && {msg_dst, msg_kind} == msg_hold_v, "R11",
                    "message held under back-pressure", 64'({msg_valid, msg_dst, msg_kind}),
                    64'({1'b1, msg_hold_v}));
            end
            msg_hold   = msg_valid && !msg_ready;
            msg_hold_v = {msg_dst, msg_kind};
            if (msg_valid && msg_ready) begin
                if (exp_msg_q.size() == 0) begin
                    chk(1'b0, "R4", {cur_tag, " unexpected message"}, 64'({msg_dst, msg_kind}), 64'hF);
                end else begin
                    chk({msg_dst, msg_kind} == exp_msg_q[0], "R4", {exp_msg_tag[0], " message dst/kind"},
                        64'({msg_dst, msg_kind}), 64'(exp_msg_q[0]));
                    void'(exp_msg_q.pop_front());
                    void'(exp_msg_tag.pop_front());
                end
                if (ack_q.size() == 0) ack_wait = 2;
                ack_q.push_back({msg_dst, msg_kind});
            end
            // response channel
            if (rsp_hold) begin
                chk(rsp_valid && {rsp_dst, rsp_data} == rsp_hold_v, "R11",
                    "response held under back-pressure", 64'({rsp_valid, rsp_dst, rsp_data}),
                    64'({1'b1, rsp_hold_v}));
            end
            rsp_hold   = rsp_valid && !rsp_ready;
            rsp_hold_v = {rsp_dst, rsp_data};
            if (txn_open) begin
                chk(!req_ready, "R9", {cur_tag, " request stalled while busy"}, 64'(req_ready), 64'd0);
            end
            if (rsp_valid && rsp_ready) begin
                if (exp_rsp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", 64'({rsp_dst, rsp_data}), 64'h0);
                end else begin
                    chk({rsp_dst, rsp_data} == exp_rsp_q[0], "R2", {exp_rsp_tag[0], " response dst/data"},
                        64'({rsp_dst, rsp_data}), 64'(exp_rsp_q[0]));
                    chk(exp_msg_q.size() == 0, "R5", {exp_rsp_tag[0], " reply only after all messages"},
                        64'(exp_msg_q.size()), 64'd0);
                    void'(exp_rsp_q.pop_front());
                    void'(exp_rsp_tag.pop_front());
                end
                txn_open  = 1'b0;
                bogus_src = -1;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 64'(cyc), 64'd0);
        summary();
    end

    initial begin
        for (int b = 0; b < NBLK; b++) begin
            m_pres[b]  = '0;
            m_dirty[b] = 1'b0;
            m_mem[b]   = SEED + DW'(b);
        end
        for (int i = 0; i < NPROC; i++) own_data[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "idle ready after reset", 64'(req_ready), 64'd1);
        chk(msg_valid == 1'b0, "R1", "no message after reset", 64'(msg_valid), 64'd0);
        chk(rsp_valid == 1'b0, "R1", "no response after reset", 64'(rsp_valid), 64'd0);

        // R2: clean reads collect sharers, home copy returned
        issue(0, 1'b0, 3, "R2 read clean p0"); wait_idle();
        issue(1, 1'b0, 3, "R2 read clean p1"); wait_idle();
        issue(2, 1'b0, 3, "R2 read clean p2"); wait_idle();
        // R4/R5: write by sharer invalidates the others in ascending order
        issue(1, 1'b1, 3, "R4 write invalidates sharers"); wait_idle();
        // R3: read of dirty block recalls from owner
        issue(3, 1'b0, 3, "R3 read recalls owner"); wait_idle();
        // R3: home copy now holds the recalled data, no messages
        issue(0, 1'b0, 3, "R3 home copy updated"); wait_idle();
        // R1/R5: write to never-touched block, directory clear so no messages
        issue(2, 1'b1, 5, "R1 write fresh block"); wait_idle();
        // R6: write to block owned by another
        issue(0, 1'b1, 5, "R6 write recalls and invalidates"); wait_idle();
        issue(1, 1'b0, 5, "R3 read recalls new owner"); wait_idle();
        // R8: owner re-accesses its block
        issue(3, 1'b1, 9, "R5 write fresh block 9"); wait_idle();
        issue(3, 1'b1, 9, "R8 owner writes again"); wait_idle();
        issue(3, 1'b0, 9, "R8 owner reads"); wait_idle();
        issue(2, 1'b0, 9, "R7 read after owner"); wait_idle();
        // R9: second request driven while a multi-sharer invalidation is open
        issue(0, 1'b1, 3, "R9 write with sharers open");
        issue(2, 1'b0, 7, "R9 stalled second request"); wait_idle();
        // mixed sweep over all blocks
        for (int b = 0; b < NBLK; b++) begin
            issue(b % NPROC, 1'b0, b, "R2 sweep read"); wait_idle();
            issue((b + 1) % NPROC, 1'b0, b, "R2 sweep read2"); wait_idle();
            issue((b + 2) % NPROC, 1'b1, b, "R4 sweep write"); wait_idle();
            issue((b + 3) % NPROC, 1'b1, b, "R6 sweep write owned"); wait_idle();
            issue(b % NPROC, 1'b0, b, "R3 sweep read owned"); wait_idle();
        end
        chk(exp_msg_q.size() == 0, "R4", "all expected messages seen", 64'(exp_msg_q.size()), 64'd0);
        chk(exp_rsp_q.size() == 0, "R5", "all expected responses seen", 64'(exp_rsp_q.size()), 64'd0);
        summary();
    end

endmodule